// File: doc/BRIEF.md
# Supply Mode Sequencing Controller

This block is the digital sequencer of a gate-driver companion chip. It watches a set of supply comparator flags and the two logic-level gate commands coming from a microcontroller. From these it steps the chip through four supply modes: startup, save, operating and fault. In each mode it drives the enables of the analog blocks around it. These are the high-voltage startup generator, the reference (off, low-current or high-current), the reference sink clamp, the two-point regulator, overcurrent protection and the gate drivers.

Every comparator flag and both gate commands pass through a two-flop synchronizer before the logic uses them. A gate command counts as switching when an edge was seen within the last `ACT_WIN` clock cycles. The dwell that must pass in save mode before full enable is counted in clock cycles, up to `DWELL_CYC`. The current mode is reported on a 2-bit status output.

Top module: `supply_seq`

## Requirements
- R1: While reset is held and just after it, the mode output is 00 (startup). In startup the startup generator and the sink clamp are on, and the reference, high-current select, regulator, overcurrent protection and drivers are off.
- R2: In startup, a set turn-on flag (`vcc_on_i`) moves the block to save mode. The mode output changes on the third rising clock edge after the flag changes, because of the two synchronizer flops and the state register.
- R3: In save mode the reference is on in low-current mode, and the sink clamp, regulator, overcurrent protection and drivers are off. The startup generator is off on entry. It turns on when `vcc_off_i` is seen and turns off again when `vcc_on_i` is seen, with no change of mode.
- R4: The block moves from save to operating only when three conditions hold together: it has spent at least `DWELL_CYC` cycles in save, the synchronized `ref_hi_i` is set, and the high-side command is switching. Operating is reached on the edge that follows `DWELL_CYC` full cycles in save, counted from the edge that entered save.
- R5: In operating mode the startup generator and the sink clamp are off, the reference is on in high-current mode, and the regulator, overcurrent protection and drivers are on.
- R6: In operating mode, loss of switching on the low-side command returns the block to save mode.
- R7: In operating mode, a set `vcc_off_i` or a set `ref_lo_i` moves the block to fault mode. Fault takes priority over a loss of switching that falls on the same edge.
- R8: In fault mode the startup generator is on and the reference is on in low-current mode. The sink clamp, regulator, overcurrent protection and drivers are off.
- R9: In save or fault mode, a set `vcc_low_i` returns the block to startup mode. No other flag leaves fault mode.
- R10: The mode output encodes the modes as 00 startup, 01 save, 10 operating and 11 fault.
- R11: The dwell count restarts each time save mode is entered, including a return from operating mode.
- R12: A gate command is switching while its last synchronized edge lies fewer than `ACT_WIN` cycles back. With no edge for `ACT_WIN` cycles, switching is lost. Measured from the last input toggle, the drop from operating to save caused by low-side silence lands on edge `ACT_WIN`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | VCC above the turn-on threshold |
| vcc_off_i | input | 1 | VCC below the turn-off threshold |
| ref_hi_i | input | 1 | Reference above 3.0 V |
| ref_lo_i | input | 1 | Reference below 2.0 V |
| vcc_low_i | input | 1 | VCC below the reference turn-off level |
| ls_cmd_i | input | 1 | Low-side gate command |
| hs_cmd_i | input | 1 | High-side gate command |
| hv_en_o | output | 1 | High-voltage startup generator enable |
| ref_en_o | output | 1 | Reference enable |
| ref_hicur_o | output | 1 | Reference high-current mode select |
| sink_en_o | output | 1 | Reference sink clamp enable |
| reg_en_o | output | 1 | Two-point regulator enable |
| ocp_en_o | output | 1 | Overcurrent protection enable |
| drv_en_o | output | 1 | Gate driver enable |
| mode_o | output | 2 | Current mode (00 startup, 01 save, 10 operating, 11 fault) |

## Verification
Two events can land on the same clock edge in operating mode: the activity window of the low-side command expires, and a supply fault flag arrives. The bench silences the low-side command. It then sets `vcc_off_i` on exactly the cycle whose two-flop delay brings the flag to the state register on the same edge where switching is declared lost. The expected result is fault mode, not save mode, and the mode output is also checked one edge earlier to confirm that neither event acted early. Around this case, a sweep over every combination of the five supply flags in each of the four modes compares the next mode with an arithmetic model of the transition rules.

// File: rtl/supply_seq.sv
module supply_seq #(
  parameter int DWELL_CYC = 1000,
  parameter int ACT_WIN   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_i,
  input  logic       vcc_off_i,
  input  logic       ref_hi_i,
  input  logic       ref_lo_i,
  input  logic       vcc_low_i,
  input  logic       ls_cmd_i,
  input  logic       hs_cmd_i,
  output logic       hv_en_o,
  output logic       ref_en_o,
  output logic       ref_hicur_o,
  output logic       sink_en_o,
  output logic       reg_en_o,
  output logic       ocp_en_o,
  output logic       drv_en_o,
  output logic [1:0] mode_o
);

  localparam int AW = $clog2(ACT_WIN + 1);
  localparam int DW = $clog2(DWELL_CYC + 1);
  localparam int NFLAG = 5;

  typedef enum logic [1:0] {
    M_START = 2'b00,
    M_SAVE  = 2'b01,
    M_OPER  = 2'b10,
    M_FAULT = 2'b11
  } mode_t;

  mode_t mode_q, mode_d;

  // flag synchronizer: [0] on, [1] off, [2] ref_hi, [3] ref_lo, [4] low
  logic [NFLAG-1:0] flg_s1, flg_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_s1 <= '0;
      flg_s2 <= '0;
    end else begin
      flg_s1 <= {vcc_low_i, ref_lo_i, ref_hi_i, vcc_off_i, vcc_on_i};
      flg_s2 <= flg_s1;
    end
  end

  wire on_s  = flg_s2[0];
  wire off_s = flg_s2[1];
  wire rhi_s = flg_s2[2];
  wire rlo_s = flg_s2[3];
  wire low_s = flg_s2[4];

  // switching activity, channel 0 low side, channel 1 high side
  logic [1:0] cmd_in, act;
  assign cmd_in = {hs_cmd_i, ls_cmd_i};

  for (genvar g = 0; g < 2; g++) begin : g_act
    logic [2:0]    pipe;
    logic [AW-1:0] cnt;
    wire           edge_seen = pipe[1] ^ pipe[2];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '0;
        cnt  <= AW'(ACT_WIN);
      end else begin
        pipe <= {pipe[1:0], cmd_in[g]};
        if (edge_seen)
          cnt <= '0;
        else if (cnt != AW'(ACT_WIN))
          cnt <= cnt + 1'b1;
      end
    end
    assign act[g] = edge_seen || (cnt != AW'(ACT_WIN));
  end

  wire ls_act = act[0];
  wire hs_act = act[1];

  // dwell in save mode
  logic [DW-1:0] dwell_q;
  wire dwell_done = (dwell_q == DW'(DWELL_CYC));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dwell_q <= '0;
    else if (mode_q != M_SAVE)
      dwell_q <= '0;
    else if (!dwell_done)
      dwell_q <= dwell_q + 1'b1;
  end

  // startup generator cycling in save mode
  logic hv_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hv_cyc <= 1'b0;
    else if (mode_q != M_SAVE || on_s)
      hv_cyc <= 1'b0;
    else if (off_s)
      hv_cyc <= 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_START: if (on_s) mode_d = M_SAVE;
      M_SAVE: begin
        if (low_s)
          mode_d = M_START;
        else if (dwell_done && rhi_s && hs_act)
          mode_d = M_OPER;
      end
      M_OPER: begin
        if (off_s || rlo_s)
          mode_d = M_FAULT;
        else if (!ls_act)
          mode_d = M_SAVE;
      end
      M_FAULT: if (low_s) mode_d = M_START;
      default: mode_d = M_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_START;
    else        mode_q <= mode_d;
  end

  wire in_oper = (mode_q == M_OPER);

  assign mode_o      = mode_q;
  assign hv_en_o     = (mode_q == M_START) || (mode_q == M_FAULT) ||
                       ((mode_q == M_SAVE) && hv_cyc);
  assign ref_en_o    = (mode_q != M_START);
  assign ref_hicur_o = in_oper;
  assign sink_en_o   = (mode_q == M_START);
  assign reg_en_o    = in_oper;
  assign ocp_en_o    = in_oper;
  assign drv_en_o    = in_oper;

  assert_oper_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OPER && $past(mode_q) == M_SAVE) |->
      ($past(dwell_q) == DW'(DWELL_CYC) && $past(rhi_s) && $past(hs_act)));

  assert_oper_from_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OPER) |-> ($past(mode_q) == M_SAVE || $past(mode_q) == M_OPER));

  assert_save_from_oper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SAVE && $past(mode_q) == M_OPER) |-> !$past(ls_act));

  assert_fault_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FAULT && $past(mode_q) != M_FAULT) |->
      ($past(mode_q) == M_OPER && ($past(off_s) || $past(rlo_s))));

  assert_start_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_START && $past(mode_q) != M_START) |-> $past(low_s));

  assert_dwell_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SAVE && $past(mode_q) != M_SAVE) |-> (dwell_q == '0));

endmodule

// File: tb/supply_seq_tb.sv
module supply_seq_tb;
  localparam int CLK_P = 10;
  localparam int DWELL = 6;
  localparam int WIN   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on = 0, vcc_off = 0, ref_hi = 0, ref_lo = 0, vcc_low = 0;
  logic ls_cmd = 0, hs_cmd = 0;
  logic ls_run = 0, hs_run = 0;
  logic hv_en, ref_en, ref_hicur, sink_en, reg_en, ocp_en, drv_en;
  logic [1:0] mode;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (ls_run) ls_cmd = ~ls_cmd;
    if (hs_run) hs_cmd = ~hs_cmd;
  end

  supply_seq #(.DWELL_CYC(DWELL), .ACT_WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .vcc_on_i(vcc_on), .vcc_off_i(vcc_off), .ref_hi_i(ref_hi),
    .ref_lo_i(ref_lo), .vcc_low_i(vcc_low),
    .ls_cmd_i(ls_cmd), .hs_cmd_i(hs_cmd),
    .hv_en_o(hv_en), .ref_en_o(ref_en), .ref_hicur_o(ref_hicur),
    .sink_en_o(sink_en), .reg_en_o(reg_en), .ocp_en_o(ocp_en),
    .drv_en_o(drv_en), .mode_o(mode)
  );

  wire [6:0] outs = {hv_en, ref_en, ref_hicur, sink_en, reg_en, ocp_en, drv_en};

  function automatic logic [6:0] exp_outs(input logic [1:0] m, input logic hv_save);
    case (m)
      2'b00:   return 7'b1001000;
      2'b01:   return {hv_save, 6'b100000};
      2'b10:   return 7'b0110111;
      default: return 7'b1100000;
    endcase
  endfunction

  function automatic logic [1:0] next_mode(input logic [1:0] m, input logic [4:0] c);
    case (m)
      2'b00:   return c[0] ? 2'b01 : 2'b00;
      2'b01:   return c[4] ? 2'b00 : 2'b01;
      2'b10:   return (c[1] || c[3]) ? 2'b11 : 2'b10;
      default: return c[4] ? 2'b00 : 2'b11;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ls_run = 0; hs_run = 0;
    {vcc_on, vcc_off, ref_hi, ref_lo, vcc_low} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_mode(input logic [1:0] m, input int limit);
    for (int i = 0; i < limit && mode != m; i++) edges(1);
  endtask

  task automatic go_to(input logic [1:0] m);
    do_reset();
    if (m == 2'b00) return;
    @(posedge clk); #2;
    if (m != 2'b01) begin ls_run = 1; hs_run = 1; end
    @(negedge clk);
    vcc_on = 1;
    if (m != 2'b01) ref_hi = 1;
    if (m == 2'b01) begin edges(3); return; end
    wait_mode(2'b10, 60);
    if (m == 2'b11) begin
      @(negedge clk); vcc_off = 1;
      edges(3);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    chk(mode == 2'b00, "R1 mode in reset", mode, 0);
    chk(outs == exp_outs(2'b00, 0), "R1 outputs in reset", outs, exp_outs(2'b00, 0));
    do_reset();
    edges(2);
    chk(mode == 2'b00 && outs == exp_outs(2'b00, 0), "R1 after reset", {mode, outs}, {2'b00, exp_outs(2'b00, 0)});

    // R2 exact latency
    @(negedge clk); vcc_on = 1;
    edges(2);
    chk(mode == 2'b00, "R2 still startup", mode, 0);
    edges(1);
    chk(mode == 2'b01, "R2 save on third edge", mode, 1);
    chk(outs == exp_outs(2'b01, 0), "R3 save outputs", outs, exp_outs(2'b01, 0));

    // R3 generator hysteresis in save
    @(negedge clk); vcc_on = 0; vcc_off = 1;
    edges(3);
    chk(hv_en == 1 && mode == 2'b01, "R3 generator on below band", {mode, hv_en}, 3);
    @(negedge clk); vcc_off = 0;
    edges(4);
    chk(hv_en == 1, "R3 generator held inside band", hv_en, 1);
    @(negedge clk); vcc_on = 1;
    edges(3);
    chk(hv_en == 0 && mode == 2'b01, "R3 generator off at top", {mode, hv_en}, 2);

    // R4 no switching on high side
    edges(DWELL + 8);
    chk(mode == 2'b01, "R4 no ref, no switching", mode, 1);
    @(negedge clk); ref_hi = 1;
    edges(DWELL + 8);
    chk(mode == 2'b01, "R4 ref but no high-side switching", mode, 1);
    // R4 no ref_hi although switching
    @(negedge clk); ref_hi = 0;
    @(posedge clk); #2; hs_run = 1; ls_run = 1;
    edges(DWELL + 8);
    chk(mode == 2'b01, "R4 switching but ref low", mode, 1);
    // switching stopped, then ref high: stays
    @(posedge clk); #2; hs_run = 0;
    edges(WIN + 6);
    @(negedge clk); ref_hi = 1;
    edges(10);
    chk(mode == 2'b01, "R12 lapsed high-side activity blocks entry", mode, 1);
    @(posedge clk); #2; hs_run = 1;
    wait_mode(2'b10, 30);
    chk(mode == 2'b10, "R4 entry once all conditions hold", mode, 2);
    chk(outs == exp_outs(2'b10, 0), "R5 operating outputs", outs, exp_outs(2'b10, 0));

    // R4 exact dwell from a fresh entry
    do_reset();
    @(posedge clk); #2; hs_run = 1; ls_run = 1;
    @(negedge clk); vcc_on = 1; ref_hi = 1;
    edges(DWELL + 3);
    chk(mode == 2'b01, "R4 dwell not yet complete", mode, 1);
    edges(1);
    chk(mode == 2'b10, "R4 operating after dwell", mode, 2);

    // R6 / R12 exact activity window on low side
    @(posedge clk); #2; ls_run = 0;
    edges(WIN + 2);
    chk(mode == 2'b10, "R12 window not yet expired", mode, 2);
    edges(1);
    chk(mode == 2'b01, "R6 back to save on low-side silence", mode, 1);
    // R11 dwell restarts on re-entry
    edges(DWELL);
    chk(mode == 2'b01, "R11 dwell restarted", mode, 1);
    edges(1);
    chk(mode == 2'b10, "R11 operating after fresh dwell", mode, 2);
    edges(1);
    chk(mode == 2'b01, "R6 low side still silent", mode, 1);

    // R7 collision: fault and activity loss on the same edge
    go_to(2'b10);
    @(posedge clk); #2; ls_run = 0;
    edges(WIN);
    @(negedge clk); vcc_off = 1;
    edges(2);
    chk(mode == 2'b10, "R7 neither event early", mode, 2);
    edges(1);
    chk(mode == 2'b11, "R7 fault wins over activity loss", mode, 3);
    chk(outs == exp_outs(2'b11, 0), "R8 fault outputs", outs, exp_outs(2'b11, 0));
    edges(WIN + 5);
    chk(mode == 2'b11, "R9 fault held without vcc_low", mode, 3);

    // R10 sweep of all flag combinations in every mode
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 32; c++) begin
        logic [1:0] em;
        go_to(2'(m));
        chk(mode == 2'(m), "R10 sweep start mode", mode, m);
        em = next_mode(2'(m), 5'(c));
        @(negedge clk);
        {vcc_low, ref_lo, ref_hi, vcc_off, vcc_on} = 5'(c);
        edges(2);
        chk(mode == 2'(m), "R10 sweep before update", mode, m);
        edges(1);
        chk(mode == em, (m == 0) ? "R2 sweep" : (m == 2) ? "R7 sweep" : "R9 sweep", mode, em);
        if (em != 2'b01)
          chk(outs == exp_outs(em, 0), (em == 2'b10) ? "R5 sweep outputs" :
              (em == 2'b11) ? "R8 sweep outputs" : "R1 sweep outputs", outs, exp_outs(em, 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule